// File: doc/BRIEF.md
# Flash Command Sequencer with Embedded-Operation Model

This block sits on the device side of a byte-wide flash bus. It watches the write cycles that arrive there and recognizes three multi-cycle command sequences: byte program, sector erase and chip erase. Each sequence starts with a fixed two-write unlock. Any write that does not fit the sequence sends the decoder back to its idle state.

An accepted command starts an embedded operation. The operation is modelled by a busy timer, and each operation kind has its own scaled cycle count. While the timer runs, reads return a polling status byte instead of array contents. When the timer expires, the change is committed to a small register array inside the block, and reads return the stored data from then on.

The array holds `SECTORS` equal sectors of `SECT_BYTES` bytes each. A testbench can therefore observe every effect through ordinary reads, with no external memory model.

A write cycle is sampled on each rising clock edge at which `ce_n` and `we_n` are both low. The bench holds each write for exactly one edge. The command addresses are matched on `addr[14:0]`. The array index is `addr[IDX_W-1:0]`, with IDX_W = log2(SECTORS*SECT_BYTES). The sector number is the upper `log2(SECTORS)` bits of that index.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset every array byte reads FFH, `busy` is low and the decoder is idle.
- R2: `rdata_drive` is high only while `ce_n`=0, `oe_n`=0 and `we_n`=1. In every other case `rdata` is 00H.
- R3: The write sequence AAH@5555H, 55H@2AAAH, A0H@5555H, then PD@PA, programs byte PA. The new value is visible once busy ends.
- R4: Programming can only clear bits. The stored value becomes old AND PD.
- R5: The write sequence AAH@5555H, 55H@2AAAH, 80H@5555H, AAH@5555H, 55H@2AAAH, then 30H at any address, sets every byte of that address's sector to FFH. Bytes in other sectors keep their values.
- R6: The same erase prefix followed by 10H@5555H sets every byte of the array to FFH.
- R7: A write whose address or data does not match the expected step returns the decoder to idle. That write is not re-evaluated as the first unlock step, so the remainder of a broken sequence changes nothing.
- R8: `busy` rises on the edge that accepts the final command write. It stays high for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles for program, sector erase or chip erase respectively.
- R9: A read while busy returns a status byte instead of array data. Bit 7 of the status byte is the complement of bit 7 of the operation's target value, and bits 6:0 are 0. The target value is old AND PD for a program and FFH for an erase.
- R10: Writes received while busy are ignored. A complete command sequence sent during busy is neither executed nor queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or polling status; 00H when the bus is released |
| rdata_drive | output | 1 | High while the block drives the data bus |
| busy | output | 1 | Embedded operation in progress |

## Verification
The embedded assertions check the following on every cycle:
- The bus is released outside a proper read.
- The decoder sits idle throughout any busy period.
- An accepted command always raises busy on the next edge.
- Each busy period ends after exactly the cycle count for its operation kind.
- A program commit never turns a 0 bit into a 1.
- An erase-in-progress read returns a 00H status byte.

Other behaviour can only be shown by the bench scenarios:
- The actual array contents after each operation.
- That neighbouring sectors survive a sector erase.
- That broken unlock sequences leave the array untouched.
- That a full command sent during busy is dropped rather than run later.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_UNL1,
    S_UNL2,
    S_PROG_ARM,
    S_ERS1,
    S_ERS2,
    S_ERS3
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_PROG,
    OP_SECT,
    OP_CHIP
  } op_e;

  localparam logic [14:0] ADDR_KEY_A = 15'h5555;
  localparam logic [14:0] ADDR_KEY_B = 15'h2AAA;
  localparam logic [7:0]  DAT_KEY_A  = 8'hAA;
  localparam logic [7:0]  DAT_KEY_B  = 8'h55;
  localparam logic [7:0]  DAT_PROG   = 8'hA0;
  localparam logic [7:0]  DAT_ERASE  = 8'h80;
  localparam logic [7:0]  DAT_SECT   = 8'h30;
  localparam logic [7:0]  DAT_CHIP   = 8'h10;

  // Program may only clear bits.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_v, input logic [7:0] new_v);
    return old_v & new_v;
  endfunction

  // Status byte seen while busy: inverted bit 7 of the target, rest zero.
  function automatic logic [7:0] poll_byte(input logic [7:0] target);
    return {~target[7], 7'b0};
  endfunction

endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic        busy,
  input  logic [14:0] addr15,
  input  logic [7:0]  wdata,
  output logic        start,
  output op_e         start_op
);

  seq_state_e st, st_nxt;
  logic at_a, at_b;

  assign at_a = (addr15 == ADDR_KEY_A);
  assign at_b = (addr15 == ADDR_KEY_B);

  always_comb begin
    st_nxt   = st;
    start    = 1'b0;
    start_op = OP_NONE;
    if (wr_stb && !busy) begin
      st_nxt = S_IDLE;
      case (st)
        S_IDLE: if (at_a && wdata == DAT_KEY_A) st_nxt = S_UNL1;
        S_UNL1: if (at_b && wdata == DAT_KEY_B) st_nxt = S_UNL2;
        S_UNL2: begin
          if (at_a && wdata == DAT_PROG)       st_nxt = S_PROG_ARM;
          else if (at_a && wdata == DAT_ERASE) st_nxt = S_ERS1;
        end
        S_PROG_ARM: begin
          start    = 1'b1;
          start_op = OP_PROG;
        end
        S_ERS1: if (at_a && wdata == DAT_KEY_A) st_nxt = S_ERS2;
        S_ERS2: if (at_b && wdata == DAT_KEY_B) st_nxt = S_ERS3;
        S_ERS3: begin
          if (wdata == DAT_SECT) begin
            start    = 1'b1;
            start_op = OP_SECT;
          end else if (at_a && wdata == DAT_CHIP) begin
            start    = 1'b1;
            start_op = OP_CHIP;
          end
        end
        default: st_nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st <= S_IDLE;
    else if (busy) st <= S_IDLE;
    else           st <= st_nxt;
  end

  // R10: the sequencer makes no progress during an embedded operation
  assert_idle_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (st == S_IDLE));

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_cmd_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int PROG_CYC = 4,
  parameter int SECT_CYC = 20,
  parameter int CHIP_CYC = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  op_e              start_op,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [7:0]       start_data,
  output logic             busy,
  output logic             commit,
  output op_e              op,
  output logic [IDX_W-1:0] idx,
  output logic [7:0]       data
);

  localparam int MAXC  = (CHIP_CYC > SECT_CYC) ?
                         ((CHIP_CYC > PROG_CYC) ? CHIP_CYC : PROG_CYC) :
                         ((SECT_CYC > PROG_CYC) ? SECT_CYC : PROG_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] last_tick(input op_e k);
    case (k)
      OP_PROG: return CNT_W'(PROG_CYC - 1);
      OP_SECT: return CNT_W'(SECT_CYC - 1);
      default: return CNT_W'(CHIP_CYC - 1);
    endcase
  endfunction

  assign commit = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      op   <= OP_NONE;
      idx  <= '0;
      data <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= last_tick(start_op);
      op   <= start_op;
      idx  <= start_idx;
      data <= start_data;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
  import flash_cmd_pkg::*;
#(
  parameter int SECTORS    = 8,
  parameter int SECT_BYTES = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    commit,
  input  op_e                                     op,
  input  logic [$clog2(SECTORS*SECT_BYTES)-1:0]   idx,
  input  logic [7:0]                              data,
  input  logic [$clog2(SECTORS*SECT_BYTES)-1:0]   rd_idx,
  output logic [7:0]                              rd_byte,
  output logic [7:0]                              tgt_byte
);

  localparam int DEPTH = SECTORS * SECT_BYTES;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int OFF_W = $clog2(SECT_BYTES);
  localparam int SEC_W = IDX_W - OFF_W;

  logic [DEPTH-1:0][7:0] cells;
  logic [SEC_W-1:0]      op_sec;

  assign op_sec = idx[IDX_W-1:OFF_W];

  for (genvar j = 0; j < DEPTH; j++) begin : g_cell
    localparam logic [SEC_W-1:0] MY_SEC = SEC_W'(j / SECT_BYTES);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 8'hFF;
      else if (commit) begin
        case (op)
          OP_CHIP: q <= 8'hFF;
          OP_SECT: if (op_sec == MY_SEC) q <= 8'hFF;
          OP_PROG: if (idx == IDX_W'(j)) q <= prog_merge(q, data);
          default: ;
        endcase
      end
    end
    assign cells[j] = q;
  end

  assign rd_byte  = cells[rd_idx];
  assign tgt_byte = cells[idx];

  // R4: a program commit never sets a bit at its target byte
  assert_prog_clears_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op == OP_PROG) |=> ((tgt_byte & ~$past(tgt_byte)) == 8'h00));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW         = 15,
  parameter int SECTORS    = 8,
  parameter int SECT_BYTES = 4,
  parameter int PROG_CYC   = 4,
  parameter int SECT_CYC   = 20,
  parameter int CHIP_CYC   = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          rdata_drive,
  output logic          busy
);

  localparam int DEPTH = SECTORS * SECT_BYTES;
  localparam int IDX_W = $clog2(DEPTH);

  logic             wr_stb;
  logic             start;
  op_e              start_op;
  logic             commit;
  op_e              op;
  logic [IDX_W-1:0] op_idx;
  logic [7:0]       op_data;
  logic [7:0]       rd_byte, tgt_byte, status;

  assign wr_stb      = !ce_n && !we_n;
  assign rdata_drive = !ce_n && !oe_n && we_n;

  flash_cmd_decoder u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .busy     (busy),
    .addr15   (addr[14:0]),
    .wdata    (wdata),
    .start    (start),
    .start_op (start_op)
  );

  flash_op_timer #(
    .IDX_W    (IDX_W),
    .PROG_CYC (PROG_CYC),
    .SECT_CYC (SECT_CYC),
    .CHIP_CYC (CHIP_CYC)
  ) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_op   (start_op),
    .start_idx  (addr[IDX_W-1:0]),
    .start_data (wdata),
    .busy       (busy),
    .commit     (commit),
    .op         (op),
    .idx        (op_idx),
    .data       (op_data)
  );

  flash_byte_array #(
    .SECTORS    (SECTORS),
    .SECT_BYTES (SECT_BYTES)
  ) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .op       (op),
    .idx      (op_idx),
    .data     (op_data),
    .rd_idx   (addr[IDX_W-1:0]),
    .rd_byte  (rd_byte),
    .tgt_byte (tgt_byte)
  );

  assign status = poll_byte((op == OP_PROG) ? prog_merge(tgt_byte, op_data) : 8'hFF);
  assign rdata  = rdata_drive ? (busy ? status : rd_byte) : 8'h00;

  // Checker-side age of the current busy period, for the duration check.
  logic [15:0] busy_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_age <= '0;
    else if (!busy) busy_age <= '0;
    else            busy_age <= busy_age + 1'b1;
  end

  function automatic int exp_len(input op_e k);
    case (k)
      OP_PROG: return PROG_CYC;
      OP_SECT: return SECT_CYC;
      default: return CHIP_CYC;
    endcase
  endfunction

  // R2: bus released whenever the read condition is absent
  assert_bus_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce_n && !oe_n && we_n) |-> (rdata == 8'h00));

  // R8: an accepted command raises busy on the following edge
  assert_start_then_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R8: a busy period lasts exactly the count for its operation
  assert_busy_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (int'(busy_age) + 1 == exp_len(op)));

  // R9: erase polling shows bit 7 low and the rest zero
  assert_erase_poll_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_drive && busy && (op == OP_SECT || op == OP_CHIP)) |-> (rdata == 8'h00));

endmodule

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;

  localparam int PROG_CYC = 4;
  localparam int SECT_CYC = 20;
  localparam int CHIP_CYC = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_drive, busy;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  flash_cmd_seq #(
    .PROG_CYC (PROG_CYC),
    .SECT_CYC (SECT_CYC),
    .CHIP_CYC (CHIP_CYC)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .rdata_drive (rdata_drive),
    .busy        (busy)
  );

  // Vector fields: [28:27] kind (0 write, 1 read-compare, 2 wait idle),
  // [26:23] requirement number, [22:8] address, [7:0] data or expected byte.
  localparam int NV = 49;
  localparam logic [28:0] VEC [NV] = '{
    // R3 program 0003 with 3C; R9 status bit7 = ~3C[7]
    {2'd0,4'd3,15'h5555,8'hAA}, {2'd0,4'd3,15'h2AAA,8'h55}, {2'd0,4'd3,15'h5555,8'hA0},
    {2'd0,4'd3,15'h0003,8'h3C}, {2'd1,4'd9,15'h0003,8'h80}, {2'd2,4'd3,15'h0000,8'h00},
    {2'd1,4'd3,15'h0003,8'h3C},
    // R4 program 0F over 3C gives 0C
    {2'd0,4'd4,15'h5555,8'hAA}, {2'd0,4'd4,15'h2AAA,8'h55}, {2'd0,4'd4,15'h5555,8'hA0},
    {2'd0,4'd4,15'h0003,8'h0F}, {2'd1,4'd9,15'h0003,8'h80}, {2'd2,4'd4,15'h0000,8'h00},
    {2'd1,4'd4,15'h0003,8'h0C},
    // R3 program 0007 with A5; R9 status = 00
    {2'd0,4'd3,15'h5555,8'hAA}, {2'd0,4'd3,15'h2AAA,8'h55}, {2'd0,4'd3,15'h5555,8'hA0},
    {2'd0,4'd3,15'h0007,8'hA5}, {2'd1,4'd9,15'h0007,8'h00}, {2'd2,4'd3,15'h0000,8'h00},
    {2'd1,4'd3,15'h0007,8'hA5},
    // R3 program 0012 with 5A
    {2'd0,4'd3,15'h5555,8'hAA}, {2'd0,4'd3,15'h2AAA,8'h55}, {2'd0,4'd3,15'h5555,8'hA0},
    {2'd0,4'd3,15'h0012,8'h5A}, {2'd2,4'd3,15'h0000,8'h00}, {2'd1,4'd3,15'h0012,8'h5A},
    // R7 wrong data in the second unlock write
    {2'd0,4'd7,15'h5555,8'hAA}, {2'd0,4'd7,15'h2AAA,8'h56}, {2'd0,4'd7,15'h5555,8'hA0},
    {2'd0,4'd7,15'h0003,8'h00}, {2'd1,4'd7,15'h0003,8'h0C},
    // R7 wrong address in the first unlock write
    {2'd0,4'd7,15'h5554,8'hAA}, {2'd0,4'd7,15'h2AAA,8'h55}, {2'd0,4'd7,15'h5555,8'hA0},
    {2'd0,4'd7,15'h0012,8'h00}, {2'd1,4'd7,15'h0012,8'h5A},
    // R5 sector erase of sector 0 via address 0001
    {2'd0,4'd5,15'h5555,8'hAA}, {2'd0,4'd5,15'h2AAA,8'h55}, {2'd0,4'd5,15'h5555,8'h80},
    {2'd0,4'd5,15'h5555,8'hAA}, {2'd0,4'd5,15'h2AAA,8'h55}, {2'd0,4'd5,15'h0001,8'h30},
    {2'd1,4'd9,15'h0001,8'h00}, {2'd2,4'd5,15'h0000,8'h00}, {2'd1,4'd5,15'h0003,8'hFF},
    {2'd1,4'd5,15'h0000,8'hFF}, {2'd1,4'd5,15'h0007,8'hA5}, {2'd1,4'd5,15'h0012,8'h5A}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_read(input logic [14:0] a, output logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 1000 && busy; g++) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic unlock();
    bus_write(15'h5555, 8'hAA);
    bus_write(15'h2AAA, 8'h55);
  endtask

  task automatic erase_prefix();
    unlock();
    bus_write(15'h5555, 8'h80);
    unlock();
  endtask

  // watchdog
  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 busy", {7'b0, busy}, 8'h00);
    bus_read(15'h0000, v); check("R1 byte0", v, 8'hFF);
    bus_read(15'h001F, v); check("R1 byte31", v, 8'hFF);
    bus_read(15'h0012, v); check("R1 byte18", v, 8'hFF);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [28:0] e;
      string tag;
      e = VEC[i];
      tag = $sformatf("R%0d vec%0d", e[26:23], i);
      case (e[28:27])
        2'd0: bus_write(e[22:8], e[7:0]);
        2'd1: begin bus_read(e[22:8], v); check(tag, v, e[7:0]); end
        default: begin
          wait_idle();
          check(tag, {7'b0, busy}, 8'h00);
        end
      endcase
    end

    // R2 bus release cases
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; addr = 15'h0007; #1;
    check("R2 ce high data", rdata, 8'h00); check("R2 ce high drive", {7'b0, rdata_drive}, 8'h00);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; #1;
    check("R2 oe high data", rdata, 8'h00); check("R2 oe high drive", {7'b0, rdata_drive}, 8'h00);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; wdata = 8'h00; #1;
    check("R2 we low data", rdata, 8'h00); check("R2 we low drive", {7'b0, rdata_drive}, 8'h00);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    bus_read(15'h0007, v); check("R2 read drives", v, 8'hA5);

    // R8 program duration, then R3 result
    unlock(); bus_write(15'h5555, 8'hA0); bus_write(15'h001F, 8'h7E);
    busy_len(n); check("R8 program cycles", 8'(n), 8'(PROG_CYC));
    bus_read(15'h001F, v); check("R3 byte31", v, 8'h7E);

    // R8 sector erase duration on sector 7
    erase_prefix(); bus_write(15'h001C, 8'h30);
    busy_len(n); check("R8 sector cycles", 8'(n), 8'(SECT_CYC));
    bus_read(15'h001F, v); check("R5 sector7 erased", v, 8'hFF);

    // R10 full program sequence during a sector erase is dropped
    erase_prefix(); bus_write(15'h0018, 8'h30);
    unlock(); bus_write(15'h5555, 8'hA0); bus_write(15'h0010, 8'h00);
    wait_idle();
    repeat (3) @(negedge clk);
    check("R10 not queued busy", {7'b0, busy}, 8'h00);
    bus_read(15'h0010, v); check("R10 byte16 untouched", v, 8'hFF);

    // R6 chip erase with R8 duration
    erase_prefix(); bus_write(15'h5555, 8'h10);
    busy_len(n); check("R8 chip cycles", 8'(n), 8'(CHIP_CYC));
    bus_read(15'h0007, v); check("R6 byte7", v, 8'hFF);
    bus_read(15'h0012, v); check("R6 byte18", v, 8'hFF);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule